// File: doc/BRIEF.md
# Two-Bit Successive-Approximation Encoder Controller

This block is the digital side of a small successive-approximation converter that turns one column's analog level into a 2-bit code. A pair of clocked comparators outside the block each report whether the analog level sits above the reference that the block currently selects. The block steers that reference through a select code, keeps the trial code in a result register, and resolves one bit per clock, most significant bit first. The two comparators take turns: the first one decides the upper bit and the second one decides the lower bit.

Once both bits are resolved, the code is loaded into a shift register and sent out serially, most significant bit first, with a valid strobe. A one-cycle done pulse follows the last serial bit. A start request is accepted only while the block is idle. The width of the code is a parameter, `NUM_BITS`, with a default of 2. The rest of this text describes the default.

Top module: `sar2_encoder`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `ser_valid_o` and `done_o` are 0 and `ref_sel_o` is the mid-scale code 2'b10.
- R2: A start seen in idle makes `ref_sel_o` equal to mid-scale (2'b10, reference index 2 of 0..3) in the following cycle, whatever the earlier result was.
- R3: In the first decision cycle only `cmp_a_i` is used. A 1 means the level is above the selected reference. The upper bit takes that value, and the next `ref_sel_o` becomes {cmp_a_i, 1}.
- R4: In the second decision cycle only `cmp_b_i` is used, and the lower bit takes its value. `cmp_b_i` has no effect in the first decision cycle, and `cmp_a_i` has no effect in the second.
- R5: When the comparators report (level >= `ref_sel_o`) for a level in 0..3, the finished code equals the level.
- R6: `ser_valid_o` is high for exactly two cycles, starting in the cycle after the second decision. `ser_data_o` carries the upper bit first and then the lower bit. `ser_valid_o` and `done_o` are never high together.
- R7: `done_o` is a single-cycle pulse in the cycle directly after the last serial bit.
- R8: A start that arrives during the decision cycles, during the serial cycles or in the done cycle is ignored. The conversion runs to its end unchanged, and no new conversion begins.
- R9: `ref_sel_o` holds the finished code from the first serial cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a conversion (accepted in idle only) |
| cmp_a_i | input | 1 | First comparator: 1 when the level is above the selected reference |
| cmp_b_i | input | 1 | Second comparator: 1 when the level is above the selected reference |
| ref_sel_o | output | NUM_BITS | Reference-select code (the current trial code) |
| ser_data_o | output | 1 | Serial code bit, upper bit first |
| ser_valid_o | output | 1 | Qualifies `ser_data_o` |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The bench converts every level from 0 to 3. Each level ends in a distinct code and takes a distinct path through the reference ladder, so a wrong step direction or a stuck bit changes the result.

In every decision cycle, the comparator that should be idle is driven to the wrong answer. A design that reads the wrong comparator, or both, then produces a wrong code.

Further runs raise start during the decision, serial and done cycles. A restart would pull the reference back to mid-scale or cut the serial burst short, so these runs show whether start is ignored. The levels are chosen so that the finished code differs from mid-scale.

// File: rtl/sar2_pkg.sv
package sar2_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_CONV  = 2'd1,
      PH_SHIFT = 2'd2,
      PH_DONE  = 2'd3
   } sar_phase_e;

endpackage

// File: rtl/sar2_seq.sv
module sar2_seq
   import sar2_pkg::*;
#(
   parameter int NUM_BITS = 2,
   localparam int CNT_W   = (NUM_BITS > 2) ? $clog2(NUM_BITS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output sar_phase_e       phase,
   output logic [CNT_W-1:0] cnt,
   output logic             init,
   output logic             decide_en,
   output logic             load,
   output logic             shift_en
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BITS - 1);

   sar_phase_e       phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      phase_d   = phase_q;
      cnt_d     = cnt_q;
      init      = 1'b0;
      decide_en = 1'b0;
      load      = 1'b0;
      shift_en  = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (start) begin
               init    = 1'b1;
               phase_d = PH_CONV;
               cnt_d   = '0;
            end
         end
         PH_CONV: begin
            decide_en = 1'b1;
            if (cnt_q == LAST) begin
               load    = 1'b1;
               phase_d = PH_SHIFT;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PH_SHIFT: begin
            shift_en = 1'b1;
            if (cnt_q == LAST) begin
               phase_d = PH_DONE;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PH_DONE: begin
            phase_d = PH_IDLE;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   assign phase = phase_q;
   assign cnt   = cnt_q;

endmodule

// File: rtl/sar2_result.sv
module sar2_result #(
   parameter int NUM_BITS = 2,
   localparam int CNT_W   = (NUM_BITS > 2) ? $clog2(NUM_BITS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                init,
   input  logic                decide_en,
   input  logic [CNT_W-1:0]    step,
   input  logic                cmp_a,
   input  logic                cmp_b,
   output logic [NUM_BITS-1:0] code_q,
   output logic [NUM_BITS-1:0] code_d
);

   localparam logic [NUM_BITS-1:0] MID = {1'b1, {(NUM_BITS-1){1'b0}}};

   logic dec_bit;

   // Even steps belong to the first comparator, odd steps to the second.
   assign dec_bit = step[0] ? cmp_b : cmp_a;

   for (genvar gi = 0; gi < NUM_BITS; gi++) begin : g_bit
      localparam int RESOLVE_STEP = NUM_BITS - 1 - gi;
      localparam int TRIAL_STEP   = NUM_BITS - 2 - gi;
      logic nxt;
      always_comb begin
         nxt = code_q[gi];
         if (init) begin
            nxt = MID[gi];
         end else if (decide_en) begin
            if (int'(step) == RESOLVE_STEP) begin
               nxt = dec_bit;
            end else if (int'(step) == TRIAL_STEP) begin
               nxt = 1'b1;
            end
         end
      end
      assign code_d[gi] = nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= MID;
      end else begin
         code_q <= code_d;
      end
   end

endmodule

// File: rtl/sar2_serializer.sv
module sar2_serializer #(
   parameter int NUM_BITS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                shift_en,
   input  logic [NUM_BITS-1:0] code,
   output logic                ser_data
);

   logic [NUM_BITS-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= code;
      end else if (shift_en) begin
         sh_q <= {sh_q[NUM_BITS-2:0], 1'b0};
      end
   end

   assign ser_data = sh_q[NUM_BITS-1];

endmodule

// File: rtl/sar2_encoder.sv
module sar2_encoder
   import sar2_pkg::*;
#(
   parameter int NUM_BITS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                cmp_a_i,
   input  logic                cmp_b_i,
   output logic [NUM_BITS-1:0] ref_sel_o,
   output logic                ser_data_o,
   output logic                ser_valid_o,
   output logic                done_o
);

   localparam int CNT_W = (NUM_BITS > 2) ? $clog2(NUM_BITS) : 1;

   if (NUM_BITS < 2 || NUM_BITS > 8) begin : g_bad_width
      $error("sar2_encoder: NUM_BITS must lie in 2..8");
   end

   sar_phase_e          phase;
   logic [CNT_W-1:0]    cnt;
   logic                init, decide_en, load, shift_en;
   logic [NUM_BITS-1:0] code_q, code_d;

   sar2_seq #(.NUM_BITS(NUM_BITS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_i),
      .phase     (phase),
      .cnt       (cnt),
      .init      (init),
      .decide_en (decide_en),
      .load      (load),
      .shift_en  (shift_en)
   );

   sar2_result #(.NUM_BITS(NUM_BITS)) u_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .init      (init),
      .decide_en (decide_en),
      .step      (cnt),
      .cmp_a     (cmp_a_i),
      .cmp_b     (cmp_b_i),
      .code_q    (code_q),
      .code_d    (code_d)
   );

   sar2_serializer #(.NUM_BITS(NUM_BITS)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .shift_en (shift_en),
      .code     (code_d),
      .ser_data (ser_data_o)
   );

   assign ref_sel_o   = code_q;
   assign ser_valid_o = (phase == PH_SHIFT);
   assign done_o      = (phase == PH_DONE);

endmodule

// File: rtl/sar2_encoder_chk.sv
module sar2_encoder_chk
   import sar2_pkg::*;
#(
   parameter int NUM_BITS = 2,
   localparam int CNT_W   = (NUM_BITS > 2) ? $clog2(NUM_BITS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                cmp_a_i,
   input  logic [NUM_BITS-1:0] ref_sel_o,
   input  logic                ser_data_o,
   input  logic                ser_valid_o,
   input  logic                done_o,
   input  sar_phase_e          phase,
   input  logic [CNT_W-1:0]    cnt,
   input  logic                decide_en
);

   localparam logic [NUM_BITS-1:0] MID = {1'b1, {(NUM_BITS-1){1'b0}}};

   logic [7:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           run_q <= '0;
      else if (ser_valid_o) run_q <= run_q + 8'd1;
      else                  run_q <= '0;
   end

   AST_MID_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && start_i) |=> (ref_sel_o == MID)); // R2

   AST_MSB_FROM_CMP_A: assert property (@(posedge clk) disable iff (!rst_n)
      (decide_en && cnt == '0) |=> (ref_sel_o[NUM_BITS-1] == $past(cmp_a_i))); // R3

   AST_SER_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_valid_o) |-> (run_q == 8'(NUM_BITS))); // R6

   AST_SER_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ser_valid_o, done_o})); // R6

   AST_FIRST_BIT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_valid_o) |-> (ser_data_o == ref_sel_o[NUM_BITS-1])); // R5

   AST_DONE_AFTER_SER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_valid_o) |-> done_o); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CONV || phase == PH_SHIFT) |=> (phase != PH_IDLE)); // R8

   AST_REF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_valid_o || done_o) |=> $stable(ref_sel_o)); // R9

endmodule

bind sar2_encoder sar2_encoder_chk #(.NUM_BITS(NUM_BITS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .cmp_a_i     (cmp_a_i),
   .ref_sel_o   (ref_sel_o),
   .ser_data_o  (ser_data_o),
   .ser_valid_o (ser_valid_o),
   .done_o      (done_o),
   .phase       (phase),
   .cnt         (cnt),
   .decide_en   (decide_en)
);

// File: tb/sar2_encoder_tb_top.sv
module sar2_encoder_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       cmp_a_i = 1'b0;
   logic       cmp_b_i = 1'b0;
   logic [1:0] ref_sel_o;
   logic       ser_data_o;
   logic       ser_valid_o;
   logic       done_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sar2_encoder #(.NUM_BITS(2)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .cmp_a_i     (cmp_a_i),
      .cmp_b_i     (cmp_b_i),
      .ref_sel_o   (ref_sel_o),
      .ser_data_o  (ser_data_o),
      .ser_valid_o (ser_valid_o),
      .done_o      (done_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(ser_valid_o == 1'b0, "R1 ser_valid in reset", int'(ser_valid_o), 0);
      check(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
      check(ref_sel_o == 2'b10, "R1 ref_sel in reset", int'(ref_sel_o), 2);
      rst_n = 1'b1;
      @(negedge clk);
      check(ser_valid_o == 1'b0 && done_o == 1'b0, "R1 outputs after release",
            int'({ser_valid_o, done_o}), 0);
      check(ref_sel_o == 2'b10, "R1 ref_sel after release", int'(ref_sel_o), 2);
   endtask

   // Comparator model: the level is above the reference when level >= index.
   // The comparator not in use is driven to the wrong answer on purpose.
   task automatic t_convert(input int level, input bit poke);
      logic [1:0] exp_code;
      bit         above;
      exp_code = 2'(level);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(ref_sel_o == 2'b10, "R2 mid-scale after start", int'(ref_sel_o), 2);
      above   = (level >= int'(ref_sel_o));
      cmp_a_i = above;
      cmp_b_i = ~above;                               // R4 must be ignored here
      @(negedge clk);
      check(ref_sel_o == {exp_code[1], 1'b1}, "R3 ref after first decision",
            int'(ref_sel_o), int'({exp_code[1], 1'b1}));
      above   = (level >= int'(ref_sel_o));
      cmp_b_i = above;
      cmp_a_i = ~above;                               // R4 must be ignored here
      if (poke) start_i = 1'b1;                       // R8 during decision
      @(negedge clk);
      start_i = 1'b0;
      check(ser_valid_o == 1'b1 && done_o == 1'b0, "R6 first serial cycle",
            int'({ser_valid_o, done_o}), 2);
      check(ser_data_o == exp_code[1], "R6 upper bit first", int'(ser_data_o), int'(exp_code[1]));
      check(ref_sel_o == exp_code, "R5 finished code", int'(ref_sel_o), level);
      cmp_a_i = 1'b1;
      cmp_b_i = 1'b0;
      if (poke) start_i = 1'b1;                       // R8 during serial output
      @(negedge clk);
      start_i = 1'b0;
      check(ser_valid_o == 1'b1, "R6 second serial cycle", int'(ser_valid_o), 1);
      check(ser_data_o == exp_code[0], "R6 lower bit second", int'(ser_data_o), int'(exp_code[0]));
      check(ref_sel_o == exp_code, "R9 ref held in serial", int'(ref_sel_o), level);
      cmp_a_i = 1'b0;
      cmp_b_i = 1'b1;
      @(negedge clk);
      check(ser_valid_o == 1'b0, "R6 serial burst length", int'(ser_valid_o), 0);
      check(done_o == 1'b1, "R7 done after last bit", int'(done_o), 1);
      check(ref_sel_o == exp_code, "R9 ref held at done", int'(ref_sel_o), level);
      if (poke) start_i = 1'b1;                       // R8 during done cycle
      @(negedge clk);
      start_i = 1'b0;
      check(done_o == 1'b0, "R7 done single cycle", int'(done_o), 0);
      check(ref_sel_o == exp_code, "R8 no restart after done-cycle start",
            int'(ref_sel_o), level);
      @(negedge clk);
      check(ser_valid_o == 1'b0 && done_o == 1'b0, "R8 stays idle",
            int'({ser_valid_o, done_o}), 0);
      check(ref_sel_o == exp_code, "R9 ref held in idle", int'(ref_sel_o), level);
   endtask

   initial begin
      t_reset_state();
      for (int lv = 0; lv < 4; lv++) t_convert(lv, 1'b0);
      t_convert(3, 1'b1);
      t_convert(0, 1'b1);
      t_convert(1, 1'b1);
      t_convert(2, 1'b0);
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule